// File: doc/BRIEF.md
# LPC Host I/O Cycle Sequencer

This block sits between a simple host-side request port and an LPC bus. A host I/O read or write of one, two or four bytes is accepted in a single handshake. The block turns it into a series of single-byte LPC I/O cycles at consecutive addresses, lowest byte first. Each byte cycle drives a start nibble, a cycle-type nibble, the 16-bit address and, for writes, the data. It then releases the bus for a turnaround and watches the target's SYNC code. For reads it collects the returned byte.

The pieces of one request are separated by a fixed 2-clock idle gap. Separate commands are held apart by a recovery gap of 22 or 54 clocks, chosen by a configuration input. If no target answers, the byte cycle is abandoned after a short timeout. A read then returns all ones for that byte, a write is discarded, and the host still receives a normal completion.

Top module: `lpc_io_seq`

## Requirements
- R1: After a synchronous reset, `lframe_n` is 1, `lad_oe` is 0, `req_ready` is 1 and `resp_valid` is 0.
- R2: Each byte cycle drives nibble 0000 with `lframe_n` low for exactly one clock. Next comes a type nibble, 0000 for a read and 0010 for a write. Then come the four address nibbles, most significant first, and for writes two data nibbles, low nibble first. `lframe_n` is high on every other clock.
- R3: `req_size` 00 gives 1 byte, 01 gives 2 bytes, and 10 or 11 give 4 bytes. Byte i goes to address `req_addr`+i (16-bit wrap) and carries `req_wdata[8i+7:8i]`. Exactly one `resp_valid` follows the last byte.
- R4: Between the byte cycles of one request, the bus is idle for exactly 2 clocks, whatever `cfg_long_gap` is.
- R5: Between the last byte cycle of a command and the start of the next command, the bus is idle for exactly 22 clocks (`cfg_long_gap`=0) or 54 clocks (`cfg_long_gap`=1) when the next request is already waiting. `cfg_long_gap` is taken at acceptance.
- R6: A SYNC of 0000 means ready. A SYNC of 0101 or 0110 means wait and extends the cycle without limit. For reads, the two nibbles after a ready SYNC are the data, low nibble first. Read byte i is returned in `resp_rdata[8i+7:8i]`, and unused upper bytes are 0.
- R7: After 4 consecutive SYNC samples that are none of 0000, 0101 or 0110, the byte cycle ends. A read byte returns FF, a write is dropped, and the request still completes.
- R8: `lad_oe` is 0 during both 2-clock turnarounds and on every clock on which the target drives SYNC or read data.
- R9: `resp_valid` is a one-clock pulse. `req_ready` is 0 from acceptance until the command's recovery gap has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LPC clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_long_gap | input | 1 | 1 selects the 54-clock command recovery, 0 the 22-clock one |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle; a request is accepted when valid and ready |
| req_write | input | 1 | 1 for an I/O write, 0 for a read |
| req_size | input | 2 | 00 = 1 byte, 01 = 2 bytes, 1x = 4 bytes |
| req_addr | input | 16 | I/O address of the lowest byte |
| req_wdata | input | 32 | Write data, byte i in bits 8i+7:8i |
| resp_valid | output | 1 | One-clock completion pulse |
| resp_rdata | output | 32 | Read data, valid with `resp_valid` |
| lframe_n | output | 1 | Frame strobe, low on the start nibble |
| lad_out | output | 4 | Nibble driven onto the LPC data lines |
| lad_oe | output | 1 | Output enable for `lad_out` |
| lad_in | input | 4 | Nibble sampled from the LPC data lines |

## Verification
Random requests of all three sizes, both directions, random addresses and both recovery settings are run against a behavioural target. The target decodes every cycle and answers with zero to two wait codes. Comparing its log with the request separates correct splitting and address stepping from byte-order or wrap errors. Measuring every idle stretch tells the fixed split gap apart from the selectable command gap. Directed cases cover long waits, unanswered reads and writes, and a two-byte request that wraps at address FFFF. These show whether the block distinguishes a wait code from an invalid one and whether it substitutes all ones only for unanswered reads.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CTYP, S_ADDR, S_WDAT, S_TAR1, S_SYNC, S_RDAT, S_TAR2, S_GAP
  } seq_state_t;

  localparam logic [3:0] NIB_START   = 4'h0;
  localparam logic [3:0] NIB_IO_RD   = 4'h0;
  localparam logic [3:0] NIB_IO_WR   = 4'h2;
  localparam logic [3:0] SYNC_READY  = 4'h0;
  localparam logic [3:0] SYNC_WAIT_S = 4'h5;
  localparam logic [3:0] SYNC_WAIT_L = 4'h6;
endpackage

// File: rtl/lpc_gap_timer.sv
module lpc_gap_timer #(
  parameter int MAX_VAL = 54
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [$clog2(MAX_VAL+1)-1:0] load_val,
  input  logic                       run,
  output logic                       done
);
  localparam int GW = $clog2(MAX_VAL + 1);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (load)                    cnt_q <= load_val;
    else if (run && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lpc_sync_mon.sv
module lpc_sync_mon
  import lpc_io_pkg::*;
#(
  parameter int LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic [3:0] lad_in,
  output logic       ready,
  output logic       expired
);
  localparam int MW = $clog2(LIMIT + 1);
  logic [MW-1:0] miss_q;
  logic          hold;
  logic          bad;

  assign ready   = active && (lad_in == SYNC_READY);
  assign hold    = active && (lad_in == SYNC_WAIT_S || lad_in == SYNC_WAIT_L);
  assign bad     = active && !ready && !hold;
  assign expired = bad && (miss_q == MW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !active) miss_q <= '0;
    else if (bad)       miss_q <= miss_q + 1'b1;
    else if (hold)      miss_q <= '0;
  end
endmodule

// File: rtl/lpc_io_seq.sv
module lpc_io_seq
  import lpc_io_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int GAP_SHORT  = 22,
  parameter int GAP_LONG   = 54,
  parameter int GAP_SPLIT  = 2,
  parameter int SYNC_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_long_gap,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              resp_valid,
  output logic [31:0]       resp_rdata,
  output logic              lframe_n,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  input  logic [3:0]        lad_in
);
  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int NIB_W     = (ADDR_NIBS > 2) ? $clog2(ADDR_NIBS) : 1;
  localparam int GAP_MAX   = (GAP_LONG > GAP_SHORT) ? GAP_LONG : GAP_SHORT;
  localparam int GW        = $clog2(GAP_MAX + 1);

  seq_state_t        st_q;
  logic [NIB_W-1:0]  nib_q;
  logic [1:0]        byte_q, last_q;
  logic [ADDR_W-1:0] addr_q, addr_sh_q;
  logic [31:0]       wdata_q, rdata_q;
  logic              write_q, long_q, cont_q;
  logic              sync_ready, sync_expired;
  logic              tar2_end, gap_done;
  logic [GW-1:0]     gap_val;

  assign tar2_end = (st_q == S_TAR2) && nib_q[0];
  assign gap_val  = (byte_q != last_q) ? GW'(GAP_SPLIT - 1)
                  : (long_q ? GW'(GAP_LONG - 2) : GW'(GAP_SHORT - 2));

  lpc_gap_timer #(.MAX_VAL(GAP_MAX)) u_gap (
    .clk(clk), .rst(rst), .load(tar2_end), .load_val(gap_val),
    .run(st_q == S_GAP), .done(gap_done)
  );

  lpc_sync_mon #(.LIMIT(SYNC_LIMIT)) u_sync (
    .clk(clk), .rst(rst), .active(st_q == S_SYNC), .lad_in(lad_in),
    .ready(sync_ready), .expired(sync_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE; nib_q <= '0; byte_q <= '0; last_q <= '0;
      addr_q <= '0; addr_sh_q <= '0; wdata_q <= '0; rdata_q <= '0;
      write_q <= 1'b0; long_q <= 1'b0; cont_q <= 1'b0; resp_valid <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          write_q <= req_write;
          long_q  <= cfg_long_gap;
          rdata_q <= '0;
          byte_q  <= '0;
          last_q  <= (req_size == 2'b00) ? 2'd0 : (req_size == 2'b01) ? 2'd1 : 2'd3;
          st_q    <= S_START;
        end
        S_START: st_q <= S_CTYP;
        S_CTYP: begin
          addr_sh_q <= addr_q + ADDR_W'(byte_q);
          nib_q     <= '0;
          st_q      <= S_ADDR;
        end
        S_ADDR: begin
          addr_sh_q <= addr_sh_q << 4;
          if (nib_q == NIB_W'(ADDR_NIBS - 1)) begin
            nib_q <= '0;
            st_q  <= write_q ? S_WDAT : S_TAR1;
          end else nib_q <= nib_q + 1'b1;
        end
        S_WDAT, S_TAR1: begin
          if (nib_q[0]) begin
            nib_q <= '0;
            st_q  <= (st_q == S_WDAT) ? S_TAR1 : S_SYNC;
          end else nib_q <= nib_q + 1'b1;
        end
        S_SYNC: begin
          if (sync_ready) begin
            nib_q <= '0;
            st_q  <= write_q ? S_TAR2 : S_RDAT;
          end else if (sync_expired) begin
            if (!write_q) rdata_q[{byte_q, 3'b000} +: 8] <= 8'hFF;
            nib_q <= '0;
            st_q  <= S_TAR2;
          end
        end
        S_RDAT: begin
          rdata_q[{byte_q, nib_q[0], 2'b00} +: 4] <= lad_in;
          if (nib_q[0]) begin
            nib_q <= '0;
            st_q  <= S_TAR2;
          end else nib_q <= nib_q + 1'b1;
        end
        S_TAR2: begin
          if (nib_q[0]) begin
            nib_q <= '0;
            st_q  <= S_GAP;
            if (byte_q == last_q) begin
              resp_valid <= 1'b1;
              cont_q     <= 1'b0;
            end else begin
              byte_q <= byte_q + 1'b1;
              cont_q <= 1'b1;
            end
          end else nib_q <= nib_q + 1'b1;
        end
        S_GAP: if (gap_done) st_q <= cont_q ? S_START : S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st_q == S_IDLE);
  assign resp_rdata = rdata_q;

  always_comb begin
    lframe_n = 1'b1;
    lad_oe   = 1'b0;
    lad_out  = 4'h0;
    case (st_q)
      S_START: begin lframe_n = 1'b0; lad_oe = 1'b1; lad_out = NIB_START; end
      S_CTYP:  begin lad_oe = 1'b1; lad_out = write_q ? NIB_IO_WR : NIB_IO_RD; end
      S_ADDR:  begin lad_oe = 1'b1; lad_out = addr_sh_q[ADDR_W-1 -: 4]; end
      S_WDAT:  begin lad_oe = 1'b1; lad_out = wdata_q[{byte_q, nib_q[0], 2'b00} +: 4]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpc_io_seq_chk.sv
module lpc_io_seq_chk #(
  parameter int GAP_SHORT = 22,
  parameter int GAP_LONG  = 54
) (
  input logic       clk,
  input logic       rst,
  input logic       lframe_n,
  input logic       lad_oe,
  input logic [3:0] lad_out,
  input logic       req_ready,
  input logic       resp_valid
);
  localparam int CW = $clog2(GAP_LONG + 2);
  logic          arm_q;
  logic [CW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0; since_q <= '0;
    end else if (resp_valid) begin
      arm_q <= 1'b1; since_q <= CW'(1);
    end else if (req_ready) begin
      arm_q <= 1'b0;
    end else if (arm_q) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_start_nibble_r2: assert property (@(posedge clk) disable iff (rst)
    !lframe_n |-> (lad_oe && lad_out == 4'h0));
  p_frame_single_r2: assert property (@(posedge clk) disable iff (rst)
    !lframe_n |=> lframe_n);
  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
  p_busy_at_resp_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !req_ready);
  p_cmd_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (arm_q && req_ready) |-> (since_q >= CW'(GAP_SHORT - 1)));
endmodule

bind lpc_io_seq lpc_io_seq_chk #(.GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) u_chk (
  .clk(clk), .rst(rst), .lframe_n(lframe_n), .lad_oe(lad_oe), .lad_out(lad_out),
  .req_ready(req_ready), .resp_valid(resp_valid)
);

// File: tb/lpc_io_seq_test.sv
`timescale 1ns/1ps
module lpc_io_seq_test;
  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_long_gap = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, resp_valid, lframe_n, lad_oe;
  logic [31:0] resp_rdata;
  logic [3:0]  lad_out;
  logic [3:0]  lad_in;

  int checks = 0, errors = 0, cyc = 0;
  // target behaviour and bookkeeping
  int tgt_mode = 0;          // 0 answers, 1 silent
  int tgt_waits = 0;
  int cur_write = 0, cur_long = 0, prev_long = 0;
  bit first_flag = 0, gap_chk = 0;
  int prev_end = 0, nlog = 0;
  logic [15:0] log_addr [4];
  logic [7:0]  log_data [4];

  lpc_io_seq uut (
    .clk(clk), .rst(rst), .cfg_long_gap(cfg_long_gap), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .lframe_n(lframe_n), .lad_out(lad_out),
    .lad_oe(lad_oe), .lad_in(lad_in)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] tgt_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic serve_cycle();
    logic [3:0] ct;
    logic [15:0] a = '0;
    logic [7:0] d = '0;
    int exp_gap;
    if (gap_chk) begin
      if (!first_flag)     exp_gap = 2;
      else if (prev_long != 0) exp_gap = 54;
      else exp_gap = 22;
      chk((cyc - prev_end - 1) == exp_gap, first_flag ? "R5 command gap" : "R4 split gap",
          cyc - prev_end - 1, exp_gap);
    end
    if (first_flag) prev_long = cur_long;
    first_flag = 0;
    gap_chk = 1;
    step(); ct = lad_out;
    chk(lad_oe && lframe_n && ct == (cur_write ? 4'h2 : 4'h0), "R2 type nibble", ct, cur_write ? 2 : 0);
    for (int i = 0; i < 4; i++) begin
      step(); a = {a[11:0], lad_out};
      if (!lad_oe || !lframe_n) chk(0, "R2 address phase drive", lad_oe, 1);
    end
    if (cur_write != 0) begin
      step(); d[3:0] = lad_out;
      step(); d[7:4] = lad_out;
    end
    for (int i = 0; i < 2; i++) begin
      step();
      if (lad_oe || !lframe_n) chk(0, "R8 first turnaround released", lad_oe, 0);
    end
    step(); // SYNC phase observed
    if (tgt_mode == 1) begin
      for (int i = 0; i < 4; i++) begin
        if (lad_oe) chk(0, "R8 released during sync", lad_oe, 0);
        step();
      end
      if (cur_write == 0) d = 8'hFF;
    end else begin
      for (int i = 0; i < tgt_waits; i++) begin
        lad_in = (i % 2 == 0) ? 4'h6 : 4'h5;
        step();
        if (lad_oe) chk(0, "R8 released during wait", lad_oe, 0);
      end
      lad_in = 4'h0;
      if (cur_write == 0) begin
        d = tgt_byte(a);
        step(); lad_in = d[3:0];
        if (lad_oe) chk(0, "R8 released during data", lad_oe, 0);
        step(); lad_in = d[7:4];
        step();
      end else step();
      lad_in = 4'hF;
    end
    if (lad_oe || !lframe_n) chk(0, "R8 second turnaround released", lad_oe, 0);
    step();
    if (lad_oe || !lframe_n) chk(0, "R8 second turnaround released", lad_oe, 0);
    prev_end = cyc;
    if (nlog < 4) begin log_addr[nlog] = a; log_data[nlog] = d; end
    nlog++;
  endtask

  initial begin
    lad_in = 4'hF;
    forever begin
      step();
      if (!rst && !lframe_n) begin
        chk(lad_oe && lad_out == 4'h0, "R2 start nibble", lad_out, 0);
        serve_cycle();
      end
    end
  end

  task automatic do_req(input bit wr, input logic [1:0] sz, input logic [15:0] ad,
                        input logic [31:0] wd, input bit lg, input int mode, input int waits);
    int nb = nbytes(sz);
    logic [31:0] exp_rd = '0;
    @(negedge clk);
    cfg_long_gap = lg; tgt_mode = mode; tgt_waits = waits;
    cur_write = wr; cur_long = lg; first_flag = 1; nlog = 0;
    req_write = wr; req_size = sz; req_addr = ad; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_long_gap = ~lg; // must not affect this command
    chk(!req_ready, "R9 ready low after accept", req_ready, 0);
    while (!resp_valid) @(negedge clk);
    chk(nlog == nb, "R3 byte cycle count", nlog, nb);
    for (int i = 0; i < nb && i < 4; i++) begin
      chk(log_addr[i] == ad + 16'(i), "R3 byte address", log_addr[i], ad + 16'(i));
      if (wr) chk(log_data[i] == wd[8*i +: 8], "R2 write data nibbles", log_data[i], wd[8*i +: 8]);
      exp_rd[8*i +: 8] = (mode == 1) ? 8'hFF : tgt_byte(ad + 16'(i));
    end
    if (!wr) chk(resp_rdata == exp_rd, mode == 1 ? "R7 unanswered read data" : "R6 read data",
                 resp_rdata, exp_rd);
    else if (mode == 1) chk(1, "R7 unanswered write completes", 1, 1);
    @(negedge clk);
    chk(!resp_valid && !req_ready, "R9 single pulse, still recovering", resp_valid, 0);
    cfg_long_gap = lg;
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(lframe_n && !lad_oe && req_ready && !resp_valid, "R1 reset state",
        {lframe_n, lad_oe, req_ready, resp_valid}, 4'b1010);
    // directed corners
    do_req(1'b1, 2'b00, 16'h0080, 32'h0000_005C, 1'b0, 0, 0);
    do_req(1'b0, 2'b10, 16'h03F8, 32'h0, 1'b1, 0, 0);
    do_req(1'b0, 2'b01, 16'hFFFF, 32'h0, 1'b0, 0, 3);
    do_req(1'b1, 2'b11, 16'h1230, 32'hDEAD_BEEF, 1'b1, 0, 5);
    do_req(1'b0, 2'b10, 16'h0400, 32'h0, 1'b0, 1, 0);
    do_req(1'b1, 2'b01, 16'h0500, 32'h0000_A55A, 1'b1, 1, 0);
    do_req(1'b0, 2'b00, 16'h0060, 32'h0, 1'b1, 0, 1);
    for (int k = 0; k < 200; k++) begin
      logic [31:0] r = $urandom;
      do_req(r[0], r[2:1], 16'($urandom), $urandom, r[3],
             (r[7:5] == 3'b000) ? 1 : 0, int'(r[9:8] % 3));
    end
    repeat (60) @(negedge clk);
    report();
  end
endmodule